// File: doc/BRIEF.md
# Stereo Transmit Sample Buffer

This block sits between a register-write path and an audio serializer. Software supplies a stereo sample as two writes: the left word first, then the right word. The right write completes the pair, and only then does the pair enter a small first-in first-out store. The serializer takes one pair per frame by pulsing a take request. The pair it receives appears on the output registers one cycle later.

The block reports when the store is full and when it is empty. It raises an interrupt when the fill level falls to a programmable mark, which is either half empty or fully empty. If the serializer asks for a pair while none is stored, the block sends silence (zeros on both channels) and sets a sticky underflow flag. That flag also drives the interrupt.

Dropping the channel enable discards everything held, including a half-written pair. Raising it again starts the stream cleanly from an empty store. This is the recovery path after an underflow, so that left and right words cannot swap places.

Top module: `stereo_tx_fifo`

## Requirements
- R1: After reset the outputs are as follows: `fifo_empty`=1, `fifo_full`=0, `uf_flag`=0, `irq`=0, and `out_left`/`out_right` are zero.
- R2: A pair is stored only when a `wr_right` follows a `wr_left` while enabled. A right write with no pending left word is ignored. A left write on its own stores nothing. Only the latest left word before the right write is used.
- R3: Pairs leave in the order they were written. After a `pop` cycle with data stored, `out_left`/`out_right` hold the oldest pair from the next cycle on. The store holds DEPTH (default 8) pairs.
- R4: `fifo_full` is 1 exactly when DEPTH pairs are stored. A pair completed while full is dropped, and the stored pairs are unchanged.
- R5: A `pop` while enabled and empty loads zero into both outputs and sets `uf_flag` on the next cycle.
- R6: `uf_flag` stays set until a cycle with `uf_clr`=1 and no new underflow. When a new underflow and `uf_clr` come in the same cycle, the flag stays set.
- R7: While `chan_en`=0, the store and any pending left word are discarded, and writes are ignored. A `pop` loads zeros without setting `uf_flag`.
- R8: With `int_en`=1 and `chan_en`=1, the level mark works as follows. When `int_lvl_empty`=0, `irq` is 1 while the stored count is at most DEPTH/2. When `int_lvl_empty`=1, `irq` is 1 only while the count is 0.
- R9: With `int_en`=1, `irq` is also 1 whenever `uf_flag` is set. With `int_en`=0, `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; low flushes the store |
| wr_left | input | 1 | Left word write strobe |
| wr_right | input | 1 | Right word write strobe; completes the pair |
| wr_data | input | SAMPLE_W | Write data for either strobe |
| int_en | input | 1 | Interrupt enable |
| int_lvl_empty | input | 1 | 0: mark at half empty, 1: mark at empty |
| uf_clr | input | 1 | Clears the underflow flag |
| pop | input | 1 | Serializer takes one pair |
| out_left | output | SAMPLE_W | Left sample delivered to the serializer |
| out_right | output | SAMPLE_W | Right sample delivered to the serializer |
| fifo_full | output | 1 | No free entry |
| fifo_empty | output | 1 | No stored pair |
| uf_flag | output | 1 | Sticky underflow indication |
| irq | output | 1 | Interrupt request |

## Verification
The bench steps the fill level through every value from empty to full under both mark settings. At each level it checks the interrupt, so a mark that is off by one shows up as an interrupt one level early or late. It pushes a pair into a full store and then drains it. A design that overwrote the oldest entry or advanced a pointer would return the wrong sequence. It also hits orphan right writes, a half pair that spans a flush, pops while disabled, and an underflow that arrives in the same cycle as the clear. A design that committed on the left write, kept the stale left word, or let the clear win would show the wrong data or a missing flag.

// File: rtl/stfifo_pkg.sv
package stfifo_pkg;
    parameter int unsigned SAMPLE_W = 24;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    typedef enum logic {
        MARK_HALF  = 1'b0,
        MARK_EMPTY = 1'b1
    } mark_e;

    // True when the fill level has reached the selected low mark.
    function automatic logic at_low_mark(input int unsigned cnt,
                                         input int unsigned depth,
                                         input mark_e mode);
        if (mode == MARK_EMPTY) return (cnt == 0);
        return (cnt <= depth / 2);
    endfunction
endpackage

// File: rtl/stfifo_pair_asm.sv
module stfifo_pair_asm
    import stfifo_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  logic    wr_left,
    input  logic    wr_right,
    input  sample_t wr_data,
    input  logic    store_full,
    output logic    push,
    output pair_t   push_pair
);
    sample_t held_left;
    logic    held_valid;

    assign push           = wr_right && held_valid && !flush && !store_full;
    assign push_pair.left  = held_left;
    assign push_pair.right = wr_data;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            held_valid <= 1'b0;
            held_left  <= '0;
        end else if (wr_left) begin
            held_valid <= 1'b1;
            held_left  <= wr_data;
        end else if (wr_right) begin
            // a right write always consumes the pending half, even when dropped
            held_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/stfifo_store.sv
module stfifo_store
    import stfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  pair_t            push_pair,
    input  logic             take,
    output pair_t            head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    pair_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             take_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign take_ok = take && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_pair;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (take_ok) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, take_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/stfifo_irq.sv
module stfifo_irq
    import stfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             int_en,
    input  logic             chan_en,
    input  mark_e            mode,
    input  logic [CNT_W-1:0] count,
    input  logic             uf,
    output logic             irq
);
    logic low;

    always_comb begin
        low = at_low_mark(32'(count), DEPTH, mode);
        irq = int_en && (uf || (chan_en && low));
    end
endmodule

// File: rtl/stereo_tx_fifo.sv
module stereo_tx_fifo
    import stfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chan_en,
    input  logic                wr_left,
    input  logic                wr_right,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                int_en,
    input  logic                int_lvl_empty,
    input  logic                uf_clr,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic                fifo_full,
    output logic                fifo_empty,
    output logic                uf_flag,
    output logic                irq
);
    logic             flush;
    logic             push;
    pair_t            push_pair;
    pair_t            head;
    pair_t            out_q;
    logic [CNT_W-1:0] count;
    logic             take;
    logic             starve;

    assign flush  = !chan_en;
    assign take   = pop && chan_en;
    assign starve = take && fifo_empty;

    stfifo_pair_asm u_asm (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .wr_left    (wr_left),
        .wr_right   (wr_right),
        .wr_data    (wr_data),
        .store_full (fifo_full),
        .push       (push),
        .push_pair  (push_pair)
    );

    stfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push),
        .push_pair (push_pair),
        .take      (take),
        .head      (head),
        .count     (count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    stfifo_irq #(.DEPTH(DEPTH)) u_irq (
        .int_en  (int_en),
        .chan_en (chan_en),
        .mode    (mark_e'(int_lvl_empty)),
        .count   (count),
        .uf      (uf_flag),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            uf_flag <= 1'b0;
        end else begin
            if (pop) out_q <= (take && !fifo_empty) ? head : '0;
            if (starve)      uf_flag <= 1'b1;
            else if (uf_clr) uf_flag <= 1'b0;
        end
    end

    assign out_left  = out_q.left;
    assign out_right = out_q.right;
endmodule

// File: rtl/stereo_tx_fifo_chk.sv
module stereo_tx_fifo_chk
    import stfifo_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                chan_en,
    input logic                int_en,
    input logic                int_lvl_empty,
    input logic                uf_clr,
    input logic                pop,
    input logic [SAMPLE_W-1:0] out_left,
    input logic [SAMPLE_W-1:0] out_right,
    input logic                fifo_full,
    input logic                fifo_empty,
    input logic                uf_flag,
    input logic                irq
);
    a_r4_full_holds: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && chan_en && !pop) |=> fifo_full);

    a_r4_not_both: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    a_r5_zero_on_starve: assert property (@(posedge clk) disable iff (rst)
        (pop && chan_en && fifo_empty) |=> (out_left == '0 && out_right == '0 && uf_flag));

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (uf_flag && !uf_clr) |=> uf_flag);

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> fifo_empty);

    a_r7_no_uf_when_off: assert property (@(posedge clk) disable iff (rst)
        (!chan_en && !uf_flag) |=> !uf_flag);

    a_r8_empty_mark: assert property (@(posedge clk) disable iff (rst)
        (int_en && chan_en && int_lvl_empty && fifo_empty) |-> irq);

    a_r9_gate: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> !irq);
endmodule

bind stereo_tx_fifo stereo_tx_fifo_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .chan_en       (chan_en),
    .int_en        (int_en),
    .int_lvl_empty (int_lvl_empty),
    .uf_clr        (uf_clr),
    .pop           (pop),
    .out_left      (out_left),
    .out_right     (out_right),
    .fifo_full     (fifo_full),
    .fifo_empty    (fifo_empty),
    .uf_flag       (uf_flag),
    .irq           (irq)
);

// File: tb/stereo_tx_fifo_tb.sv
module stereo_tx_fifo_tb;
    import stfifo_pkg::*;

    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chan_en = 1'b0;
    logic wr_left = 1'b0;
    logic wr_right = 1'b0;
    logic [SAMPLE_W-1:0] wr_data = '0;
    logic int_en = 1'b0;
    logic int_lvl_empty = 1'b0;
    logic uf_clr = 1'b0;
    logic pop = 1'b0;
    logic [SAMPLE_W-1:0] out_left;
    logic [SAMPLE_W-1:0] out_right;
    logic fifo_full;
    logic fifo_empty;
    logic uf_flag;
    logic irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    stereo_tx_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .wr_left(wr_left),
        .wr_right(wr_right), .wr_data(wr_data), .int_en(int_en),
        .int_lvl_empty(int_lvl_empty), .uf_clr(uf_clr), .pop(pop),
        .out_left(out_left), .out_right(out_right), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .uf_flag(uf_flag), .irq(irq)
    );

    function automatic logic [SAMPLE_W-1:0] lval(input int i);
        return SAMPLE_W'(32'h0A0000 + i * 32'h111);
    endfunction
    function automatic logic [SAMPLE_W-1:0] rval(input int i);
        return SAMPLE_W'(32'h500000 + i * 32'h2B3 + 5);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic put_left(input logic [SAMPLE_W-1:0] v);
        wr_left = 1'b1; wr_data = v; tick(); wr_left = 1'b0;
    endtask
    task automatic put_right(input logic [SAMPLE_W-1:0] v);
        wr_right = 1'b1; wr_data = v; tick(); wr_right = 1'b0;
    endtask
    task automatic put_pair(input logic [SAMPLE_W-1:0] l, input logic [SAMPLE_W-1:0] r);
        put_left(l); put_right(r);
    endtask
    task automatic take();
        pop = 1'b1; tick(); pop = 1'b0;
    endtask
    task automatic restart();
        chan_en = 1'b0; tick(); chan_en = 1'b1; tick();
    endtask
    task automatic clear_uf();
        uf_clr = 1'b1; tick(); uf_clr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 empty", fifo_empty, 1);
        chk("R1 full", fifo_full, 0);
        chk("R1 uf", uf_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 outl", out_left, 0);
        chk("R1 outr", out_right, 0);

        chan_en = 1'b1;
        int_en  = 1'b1;
        tick();

        // R3 R4 R8 sweep of every level for both marks
        for (int mode = 0; mode < 2; mode++) begin
            int_lvl_empty = mode[0];
            restart();
            for (int n = 0; n <= DEPTH; n++) begin
                chk("R4 full level", fifo_full, (n == DEPTH));
                chk("R3 empty level", fifo_empty, (n == 0));
                chk("R8 irq mark", irq, (mode == 1) ? (n == 0) : (n <= DEPTH / 2));
                if (n < DEPTH) put_pair(lval(n + mode * 16), rval(n + mode * 16));
            end
            // R4 pair while full is dropped
            put_pair(24'h0DEAD1, 24'h0DEAD2);
            chk("R4 still full", fifo_full, 1);
            for (int i = 0; i < DEPTH; i++) begin
                take();
                chk("R3 order left", out_left, lval(i + mode * 16));
                chk("R3 order right", out_right, rval(i + mode * 16));
            end
            chk("R3 drained", fifo_empty, 1);
            // R5 underflow
            take();
            chk("R5 zero left", out_left, 0);
            chk("R5 zero right", out_right, 0);
            chk("R5 flag", uf_flag, 1);
            chk("R9 irq on uf", irq, 1);
            clear_uf();
            chk("R6 cleared", uf_flag, 0);
        end

        // R2 orphan right ignored, left alone stores nothing
        int_lvl_empty = 1'b1;
        restart();
        put_right(24'h123456);
        chk("R2 orphan right", fifo_empty, 1);
        put_left(24'h000111);
        chk("R2 left alone", fifo_empty, 1);
        put_left(24'h000222);
        put_right(24'h000333);
        chk("R2 one pair", fifo_empty, 0);
        take();
        chk("R2 latest left", out_left, 24'h000222);
        chk("R2 right", out_right, 24'h000333);

        // R7 pending left discarded across flush
        put_left(24'h0AAAAA);
        restart();
        put_right(24'h0BBBBB);
        chk("R7 half pair lost", fifo_empty, 1);

        // R7 writes ignored while disabled, pop gives zeros without underflow
        put_pair(24'h001001, 24'h002002);
        chan_en = 1'b0;
        tick();
        chk("R7 flushed", fifo_empty, 1);
        put_pair(24'h003003, 24'h004004);
        take();
        chk("R7 zero out", out_left, 0);
        chk("R7 no uf", uf_flag, 0);
        chk("R8 no mark irq when off", irq, 0);
        chan_en = 1'b1;
        tick();
        chk("R7 writes ignored", fifo_empty, 1);

        // R6 underflow and clear in the same cycle: set wins
        pop = 1'b1; uf_clr = 1'b1; tick(); pop = 1'b0; uf_clr = 1'b0;
        chk("R6 set wins", uf_flag, 1);
        tick();
        chk("R6 sticky", uf_flag, 1);

        // R9 gate
        int_en = 1'b0;
        tick();
        chk("R9 gated", irq, 0);
        clear_uf();
        int_en = 1'b1;
        tick();
        chk("R8 empty mark", irq, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule